// File: doc/BRIEF.md
# Training-Pattern Frame and Phase Aligner

This block sits on the receive side of a time-multiplexed analog link. During link training the far-end multiplexer drives one of its N slots to a level well above the other N-1 slots. The receiver digitises the line one sample per slot, and this block reads that stream of ADC codes. Its first job is to find the slot position, counted within each N-sample frame, that carries the raised level. That position is reported as the channel offset, so later demultiplexing gives every sample to the right channel.

With the frame aligned, the block tunes the relative phase between the multiplexer clock and the converter clock. It does this through a request/acknowledge step interface in front of an external phase shifter. It measures the slot contrast at the starting phase and then steps the phase upward until the contrast has dropped to half. That point is the upper transient edge. It then steps downward past the start until the contrast is down to half again, which is the lower transient edge. Finally it steps up to the midpoint of the two edges and raises done. If training fails, it raises error and stops instead.

Each contrast figure is built from a whole number of frames so that noise averages out. After each phase step the block waits for the acknowledge and then a settle interval before it measures again.

Top module: `tdm_train_aligner`

## Requirements
- R1: After reset, done, error and phase_req are 0, phase_pos is 0 and chan_offset is 0.
- R2: The slot index counts valid samples modulo N_SLOTS (8), and the first valid sample after the start cycle is slot 0. chan_offset is the slot with the largest averaged code. A tie goes to the lowest index.
- R3: Each measurement covers exactly 2^AVG_LOG2 whole frames and begins at a slot-0 sample. Cycles with adc_valid low contribute nothing.
- R4: Contrast is N_SLOTS times the sum for the chosen slot, minus the sum over all slots. If the alignment contrast is not above THRESH, the block enters error with phase_pos still at 0.
- R5: After alignment the phase is stepped +1 per step. The first phase whose doubled contrast is at or below the contrast measured at phase 0 is the upper edge.
- R6: From the upper edge the phase is stepped −1 per step. The first phase that meets the same half-contrast test is the lower edge.
- R7: The final phase is floor((upper+lower)/2), reached by +1 steps with no further measurement. done is then raised.
- R8: A step is a one-cycle phase_req with phase_up held (1 = increment). phase_pos changes by exactly ±1, only on the cycle after phase_ack is seen, and measuring resumes SETTLE_CYC cycles later.
- R9: If either edge search takes MAX_STEPS steps without finding its edge, error is raised and the phase stays where it is.
- R10: done and error are never both set. Each one, together with chan_offset and phase_pos, holds until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a training run (taken when idle, done or error) |
| adc_valid | input | 1 | adc_code carries a sample this cycle |
| adc_code | input | CODE_W | Unsigned converter code |
| phase_ack | input | 1 | Phase shifter has applied the requested step |
| phase_req | output | 1 | One-cycle request for one phase step |
| phase_up | output | 1 | Step direction: 1 increment, 0 decrement |
| chan_offset | output | log2(N_SLOTS) | Slot position of channel one |
| phase_pos | output | PH_W | Signed phase, in steps from the start phase |
| done | output | 1 | Training finished successfully |
| error | output | 1 | Training failed |

## Verification
The block is run against a modelled transmitter. That model places the raised slot at several frame positions and makes its contrast drop to a quarter outside a chosen window of phases. The window edges are set so that the midpoint rounds to zero, to a negative value with flooring, and to a point right next to the lower edge. Each window separates correct edge bookkeeping from off-by-one errors and from wrong rounding. One run thins the sample stream with invalid cycles, which tells frame counting on valid samples apart from counting on clocks. A flat pattern checks the alignment threshold, a window wider than the step limit checks the search limit, and a clean run after an error checks that the block restarts.

// File: rtl/tdm_align_pkg.sv
package tdm_align_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_MEAS, S_EVAL, S_REQ, S_WAIT, S_SETTLE, S_DONE, S_ERR
  } align_state_e;

  typedef enum logic [1:0] {
    M_ALIGN, M_UP, M_DN, M_CTR
  } search_mode_e;
endpackage

// File: rtl/tdm_slot_accum.sv
// Per-slot code accumulation over a whole number of frames.
module tdm_slot_accum #(
  parameter int N_SLOTS  = 8,
  parameter int CODE_W   = 12,
  parameter int AVG_LOG2 = 4,
  localparam int SLOT_W  = $clog2(N_SLOTS),
  localparam int SUM_W   = CODE_W + AVG_LOG2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              meas_go,
  input  logic              valid,
  input  logic [CODE_W-1:0] code,
  output logic [SUM_W-1:0]  sums_o [N_SLOTS],
  output logic              meas_done
);
  localparam int CNT_W = SLOT_W + AVG_LOG2;

  logic [SLOT_W-1:0] slot, slot_n;
  logic [CNT_W-1:0]  cnt, cnt_n;
  logic              waiting, waiting_n, active, active_n;
  logic              acc_en, last;
  logic [SUM_W-1:0]  sums [N_SLOTS];
  logic [SUM_W-1:0]  sums_n [N_SLOTS];

  always_comb begin
    acc_en    = valid && !meas_go && (active || (waiting && slot == '0));
    last      = acc_en && (cnt == '1);
    slot_n    = clear ? '0 : (valid ? slot + 1'b1 : slot);
    cnt_n     = meas_go ? '0 : (acc_en ? cnt + 1'b1 : cnt);
    active_n  = meas_go ? 1'b0 : (acc_en ? !last : active);
    waiting_n = meas_go ? 1'b1 : (acc_en ? 1'b0 : waiting);
    for (int i = 0; i < N_SLOTS; i++) sums_n[i] = meas_go ? '0 : sums[i];
    if (acc_en) sums_n[slot] = sums[slot] + {{AVG_LOG2{1'b0}}, code};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot      <= '0;
      cnt       <= '0;
      waiting   <= 1'b0;
      active    <= 1'b0;
      meas_done <= 1'b0;
      for (int i = 0; i < N_SLOTS; i++) sums[i] <= '0;
    end else begin
      slot      <= slot_n;
      cnt       <= cnt_n;
      waiting   <= waiting_n;
      active    <= active_n;
      meas_done <= last;
      for (int i = 0; i < N_SLOTS; i++) sums[i] <= sums_n[i];
    end
  end

  assign sums_o = sums;
endmodule

// File: rtl/tdm_contrast_eval.sv
// Peak slot search and contrast of a chosen slot against the frame total.
module tdm_contrast_eval #(
  parameter int N_SLOTS = 8,
  parameter int SUM_W   = 16,
  localparam int SLOT_W = $clog2(N_SLOTS),
  localparam int TOT_W  = SUM_W + SLOT_W,
  localparam int CON_W  = TOT_W + 1
) (
  input  logic [SUM_W-1:0]        sums_i [N_SLOTS],
  input  logic                    sel_fixed,
  input  logic [SLOT_W-1:0]       fixed_idx,
  output logic [SLOT_W-1:0]       peak_idx,
  output logic signed [CON_W-1:0] contrast_o
);
  logic [TOT_W-1:0]  total;
  logic [SLOT_W-1:0] peak, pick;

  always_comb begin
    total = '0;
    peak  = '0;
    for (int i = 0; i < N_SLOTS; i++) begin
      total = total + TOT_W'(sums_i[i]);
      if (sums_i[i] > sums_i[peak]) peak = SLOT_W'(i);
    end
    pick       = sel_fixed ? fixed_idx : peak;
    contrast_o = $signed({1'b0, sums_i[pick], {SLOT_W{1'b0}}}) - $signed({1'b0, total});
  end

  assign peak_idx = peak;
endmodule

// File: rtl/tdm_train_aligner.sv
module tdm_train_aligner
  import tdm_align_pkg::*;
#(
  parameter int N_SLOTS    = 8,
  parameter int CODE_W     = 12,
  parameter int AVG_LOG2   = 4,
  parameter int SETTLE_CYC = 4,
  parameter int MAX_STEPS  = 32,
  parameter int PH_W       = 8,
  parameter int THRESH     = 256,
  localparam int SLOT_W    = $clog2(N_SLOTS),
  localparam int SUM_W     = CODE_W + AVG_LOG2,
  localparam int CON_W     = SUM_W + SLOT_W + 1,
  localparam int STEP_W    = $clog2(MAX_STEPS + 1),
  localparam int SET_W     = $clog2(SETTLE_CYC + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start,
  input  logic                   adc_valid,
  input  logic [CODE_W-1:0]      adc_code,
  input  logic                   phase_ack,
  output logic                   phase_req,
  output logic                   phase_up,
  output logic [SLOT_W-1:0]      chan_offset,
  output logic signed [PH_W-1:0] phase_pos,
  output logic                   done,
  output logic                   error
);
  align_state_e state, state_n;
  search_mode_e mode, mode_n;
  logic [SLOT_W-1:0]       offset_q, offset_n, peak_idx;
  logic signed [CON_W-1:0] c0_q, c0_n, contrast;
  logic signed [CON_W:0]   twice_c;
  logic signed [PH_W-1:0]  pos_q, pos_n, left_q, left_n, mid_q, mid_n, mid_calc;
  logic signed [PH_W:0]    sum_lr;
  logic                    up_q, up_n, edge_hit, meas_go, take_start;
  logic [STEP_W-1:0]       step_q, step_n;
  logic [SET_W-1:0]        set_q, set_n;
  logic [SUM_W-1:0]        sums [N_SLOTS];
  logic                    meas_done;

  tdm_slot_accum #(.N_SLOTS(N_SLOTS), .CODE_W(CODE_W), .AVG_LOG2(AVG_LOG2)) u_accum (
    .clk(clk), .rst_n(rst_n), .clear(take_start), .meas_go(meas_go),
    .valid(adc_valid), .code(adc_code), .sums_o(sums), .meas_done(meas_done));

  tdm_contrast_eval #(.N_SLOTS(N_SLOTS), .SUM_W(SUM_W)) u_eval (
    .sums_i(sums), .sel_fixed(mode != M_ALIGN), .fixed_idx(offset_q),
    .peak_idx(peak_idx), .contrast_o(contrast));

  always_comb begin
    twice_c  = {contrast, 1'b0};
    edge_hit = twice_c <= $signed({c0_q[CON_W-1], c0_q});
    sum_lr   = $signed({left_q[PH_W-1], left_q}) + $signed({pos_q[PH_W-1], pos_q});
    mid_calc = sum_lr[PH_W:1];
  end

  always_comb begin
    state_n = state;  mode_n = mode;  offset_n = offset_q;  c0_n = c0_q;
    pos_n = pos_q;  left_n = left_q;  mid_n = mid_q;  up_n = up_q;
    step_n = step_q;  set_n = set_q;  meas_go = 1'b0;
    take_start = start && (state == S_IDLE || state == S_DONE || state == S_ERR);
    case (state)
      S_MEAS: if (meas_done) state_n = S_EVAL;
      S_EVAL: begin
        state_n = S_REQ;
        case (mode)
          M_ALIGN:
            if (contrast <= $signed(CON_W'(THRESH))) state_n = S_ERR;
            else begin
              offset_n = peak_idx;  c0_n = contrast;
              mode_n = M_UP;  up_n = 1'b1;  step_n = '0;
            end
          M_UP:
            if (edge_hit) begin
              left_n = pos_q;  mode_n = M_DN;  up_n = 1'b0;  step_n = '0;
            end else if (step_q == STEP_W'(MAX_STEPS)) state_n = S_ERR;
          M_DN:
            if (edge_hit) begin
              mid_n = mid_calc;  mode_n = M_CTR;  up_n = 1'b1;
              if (mid_calc == pos_q) state_n = S_DONE;
            end else if (step_q == STEP_W'(MAX_STEPS)) state_n = S_ERR;
          default: state_n = S_DONE;
        endcase
      end
      S_REQ: state_n = S_WAIT;
      S_WAIT:
        if (phase_ack) begin
          pos_n  = up_q ? pos_q + PH_W'(1) : pos_q - PH_W'(1);
          step_n = (mode == M_CTR) ? step_q : step_q + 1'b1;
          set_n  = '0;
          state_n = S_SETTLE;
        end
      S_SETTLE:
        if (set_q == SET_W'(SETTLE_CYC - 1)) begin
          if (mode == M_CTR) state_n = (pos_q == mid_q) ? S_DONE : S_REQ;
          else begin
            meas_go = 1'b1;
            state_n = S_MEAS;
          end
        end else set_n = set_q + 1'b1;
      default: ;
    endcase
    if (take_start) begin
      pos_n = '0;  mode_n = M_ALIGN;  meas_go = 1'b1;  state_n = S_MEAS;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE;  mode <= M_ALIGN;  offset_q <= '0;  c0_q <= '0;
      pos_q <= '0;  left_q <= '0;  mid_q <= '0;  up_q <= 1'b1;
      step_q <= '0;  set_q <= '0;
    end else begin
      state <= state_n;  mode <= mode_n;  offset_q <= offset_n;  c0_q <= c0_n;
      pos_q <= pos_n;  left_q <= left_n;  mid_q <= mid_n;  up_q <= up_n;
      step_q <= step_n;  set_q <= set_n;
    end
  end

  assign phase_req   = (state == S_REQ);
  assign phase_up    = up_q;
  assign chan_offset = offset_q;
  assign phase_pos   = pos_q;
  assign done        = (state == S_DONE);
  assign error       = (state == S_ERR);

  AST_REQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    phase_req |=> !phase_req); // R8
  AST_POS_ON_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_pos != $past(phase_pos)) |-> ($past(phase_ack) || $past(start))); // R8
  AST_POS_UNIT: assert property (@(posedge clk) disable iff (!rst_n)
    ((phase_pos != $past(phase_pos)) && !$past(start)) |->
      ((phase_pos - $past(phase_pos) == PH_W'(1)) || ($past(phase_pos) - phase_pos == PH_W'(1)))); // R8
  AST_DONE_ERR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && error)); // R10
  AST_ERR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (error && !start) |=> (error && $stable(phase_pos))); // R10
  AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> (done && $stable(chan_offset) && $stable(phase_pos))); // R10
endmodule

// File: tb/tdm_train_aligner_tb_top.sv
`timescale 1ns/1ps
module tdm_train_aligner_tb_top;
  localparam int LO = 1000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic adc_valid = 1'b0;
  logic [11:0] adc_code = '0;
  logic phase_ack = 1'b0;
  logic phase_req, phase_up, done, error;
  logic [2:0] chan_offset;
  logic signed [7:0] phase_pos;

  int compared = 0, mismatched = 0;
  int cfg_off = 0, cfg_lt = 1, cfg_rt = -1;
  bit cfg_gaps = 0, cfg_flat = 0, hold = 0, mon_en = 0, mdir = 1;
  int idx = 0, mpos = 0, cyc = 0, maxp = 0, minp = 0;

  tdm_train_aligner dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .adc_valid(adc_valid),
    .adc_code(adc_code), .phase_ack(phase_ack), .phase_req(phase_req),
    .phase_up(phase_up), .chan_offset(chan_offset), .phase_pos(phase_pos),
    .done(done), .error(error));

  always #10 clk = ~clk;

  function automatic int amp(int p);
    if (cfg_flat) return 0;
    return (p >= cfg_lt || p <= cfg_rt) ? 200 : 800;
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // transmitter model: raised slot level follows the bench's own phase copy
  initial forever begin
    @(negedge clk); #1;
    cyc++;
    adc_valid = !hold && (!cfg_gaps || (cyc % 3) != 0);
    adc_code  = (adc_valid && (idx % 8) == cfg_off) ? 12'(LO + amp(mpos)) : 12'(LO);
  end

  always @(posedge clk) begin
    if (start) idx <= 0;
    else if (adc_valid) idx <= idx + 1;
    if (start) mpos <= 0;
    else if (phase_ack) mpos <= mpos + (mdir ? 1 : -1);
  end

  // phase shifter model: acknowledge two cycles after a request
  initial forever begin
    @(negedge clk);
    if (phase_req) begin
      mdir = phase_up;
      @(negedge clk); phase_ack = 1'b1;
      @(negedge clk); phase_ack = 1'b0;
    end
  end

  // per-clock comparison of the phase against the reference copy (R8)
  always @(negedge clk) begin
    if (mon_en) begin
      #2;
      check(int'(phase_pos) == mpos, "R8 phase", int'(phase_pos), mpos);
      if (start) begin maxp = 0; minp = 0; end
      else begin
        if (int'(phase_pos) > maxp) maxp = int'(phase_pos);
        if (int'(phase_pos) < minp) minp = int'(phase_pos);
      end
    end
  end

  function automatic int floor_half(int s);
    return (s >= 0) ? s / 2 : -((-s + 1) / 2);
  endfunction

  task automatic run_case(string tag, int off, int lt, int rt, bit gaps, bit flat,
                          bit exp_done, int exp_pos);
    int n;
    @(negedge clk);
    cfg_off = off; cfg_lt = lt; cfg_rt = rt; cfg_gaps = gaps; cfg_flat = flat;
    hold = 1'b1; start = 1'b1;
    @(negedge clk);
    start = 1'b0; hold = 1'b0;
    n = 0;
    while (!(done || error) && n < 30000) begin @(negedge clk); n++; end
    #3;
    check(n < 30000, {tag, " completion"}, n, 30000);
    check(done == exp_done, {tag, exp_done ? " R7 done" : " R9/R4 done low"}, done, exp_done);
    check(error == !exp_done, {tag, " R4/R9 error"}, error, !exp_done);
    check(int'(phase_pos) == exp_pos, {tag, " R7/R9 final phase"}, int'(phase_pos), exp_pos);
    if (exp_done) begin
      check(chan_offset == 3'(off), {tag, " R2 offset"}, chan_offset, off);
      check(maxp == lt, {tag, " R5 upper edge"}, maxp, lt);
      check(minp == rt, {tag, " R6 lower edge"}, minp, rt);
    end
    repeat (20) @(negedge clk);
    #3;
    check(done == exp_done && error == !exp_done, {tag, " R10 hold"}, {done, error}, {exp_done, !exp_done});
    check(int'(phase_pos) == exp_pos, {tag, " R10 phase hold"}, int'(phase_pos), exp_pos);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(!done && !error && !phase_req, "R1 flags", {done, error, phase_req}, 0);
    check(phase_pos == 0 && chan_offset == 0, "R1 regs", int'(phase_pos), 0);
    rst_n = 1'b1;
    @(negedge clk);
    mon_en = 1'b1;
    run_case("A", 3, 5, -4, 0, 0, 1, floor_half(5 - 4));
    run_case("B R3 gaps", 6, 2, -7, 1, 0, 1, floor_half(2 - 7));
    run_case("C", 0, 1, -2, 0, 0, 1, floor_half(1 - 2));
    run_case("D R4 flat", 2, 1, -1, 0, 1, 0, 0);
    run_case("E R9 no edge", 5, 100, -100, 0, 0, 0, 32);
    run_case("F restart", 1, 3, -3, 0, 0, 1, 0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    mismatched++;
    compared++;
    $display("FAIL watchdog actual=%0d expected=%0d", 190000, 0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule